// File: doc/BRIEF.md
# Platform reset cause classifier

This block observes every event that can reset the platform and names the kind of reset each one calls for. The answer is a type code from 1 to 5, issued on a one-cycle strobe. Software steers part of the decision through a reset control register. That register sits at I/O port 0xCF9 and is written through a plain byte write interface. A sticky global bit in this register escalates software and shutdown requests to type 4. Its full-reset bit picks type 2 over type 1 for the button, for software requests and for shutdown.

The other sources are:
- a raw reset button, debounced inside the block;
- a power button that must be held for a long, tick-measured interval;
- the core power-good level and an S5 state indication;
- single-cycle pulses from the thermal sensor, two watchdogs, the CPU shutdown cycle and two entry-sequence timeouts.

When several events fall in the same cycle, the largest type wins and exactly one strobe is issued. The block only classifies. Rail sequencing and the reset pins belong to the power sequencer that consumes the strobe.

Top module: `rst_cause_classifier`

## Requirements
- R1: Each qualifying event sampled at a clock edge yields `rst_valid` high for exactly one cycle, on the next edge, with `rst_type` in the range 1..5. In any cycle with no qualifying event, `rst_valid` stays low.
- R2: A write to address 0x0CF9 of data 0x06 yields type 1, and of data 0x0E yields type 2, while the global bit is clear. Writes to other addresses, and writes of other values, raise no strobe.
- R3: Any write to 0x0CF9 with data bit 7 set sets the global bit. Only the power-on reset `por_n` clears it. While it is set, a write of 0x06 or 0x0E yields type 4.
- R4: Every write to 0x0CF9 loads the full-reset bit from data bit 3. A reset button press yields type 2 if that bit is 1 and type 1 if it is 0, whatever the global bit. A press counts only after the synchronised input has stayed low for `DEB_TICKS` ticks. It gives one strobe per press, and shorter glitches have no effect.
- R5: The first OS watchdog expiry gives no strobe and only arms a count. An expiry while armed yields type 1. Any issued strobe disarms the count.
- R6: A fall of `core_pwr_ok` while the state was S0 (`sys_in_s5` low) yields type 4. A rise of `sys_in_s5` yields type 3. A fall of `core_pwr_ok` while in S5 raises no strobe.
- R7: A thermal trip, an S5 entry timeout, a firmware watchdog expiry, or the power button held low for `HOLD_TICKS` ticks yields type 5. A hold gives one strobe per press.
- R8: A CPU shutdown pulse yields type 4 if the global bit is set. Otherwise it yields type 2 if the full-reset bit is 1, and type 1 if it is 0.
- R9: A host partition reset entry timeout yields type 4.
- R10: Events in the same cycle produce one strobe that carries the highest type among them.
- R11: After power-on reset, no strobe is pending and the global bit, the full-reset bit and the watchdog arm are all clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Synchronous active-low power-on reset |
| io_wr_en | input | 1 | Byte write strobe of the I/O interface |
| io_addr | input | 16 | I/O write address |
| io_wr_data | input | 8 | I/O write data |
| rst_btn_n | input | 1 | Raw reset button, low when pressed |
| pwr_btn_n | input | 1 | Raw power button, low when pressed |
| core_pwr_ok | input | 1 | Core power-good level |
| sys_in_s5 | input | 1 | High when the platform is in S5, low in S0 |
| therm_trip | input | 1 | Catastrophic thermal trip pulse |
| cpu_shutdown | input | 1 | CPU shutdown cycle pulse |
| os_wdt_expire | input | 1 | OS watchdog reached-zero pulse |
| fw_wdt_expire | input | 1 | Firmware hang watchdog pulse |
| host_rst_tmo | input | 1 | Host partition reset entry timeout pulse |
| s5_entry_tmo | input | 1 | S5 entry sequence timeout pulse |
| rst_valid | output | 1 | One-cycle reset decision strobe |
| rst_type | output | 3 | Reset type code 1..5, valid with the strobe |

## Verification
The bench builds the block with `TICK_DIV` = 2, `DEB_TICKS` = 3 and `HOLD_TICKS` = 8. With these values the debounce settles in about ten cycles and the power button override in about twenty. A button glitch, a debounced press held well past its window, and a full override hold therefore all fit in short observation windows. The bench can then show that each press gives exactly one strobe. The address and data width parameters keep their defaults.

// File: rtl/rcc_pkg.sv
// Shared definitions for the reset cause classifier.
// Assumes: reset type codes are 3 bits wide, 0 meaning "no reset".
package rcc_pkg;
    typedef enum logic [2:0] {
        RT_NONE   = 3'd0,
        RT_WARM   = 3'd1,
        RT_COLD   = 3'd2,
        RT_SOFT5  = 3'd3,
        RT_GLOBAL = 3'd4,
        RT_OFF    = 3'd5
    } rst_type_e;

    localparam int NUM_TYPES = 5;
endpackage

// File: rtl/rcc_tick_gen.sv
// Free-running prescaler: emits one-cycle tick every TICK_DIV clocks.
// Assumes: TICK_DIV >= 1; synchronous active-low reset.
module rcc_tick_gen #(
    parameter int TICK_DIV = 125000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] div_q;

    // Count clocks up to the tick boundary and wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)              div_q <= '0;
        else if (div_q == LAST)  div_q <= '0;
        else                     div_q <= div_q + 1'b1;
    end

    assign tick = (div_q == LAST);
endmodule

// File: rtl/rcc_hold_det.sv
// Button hold detector: synchronises a raw active-low button and pulses
// fire once after it has been low for HOLD_TICKS ticks. Releasing restarts.
// Assumes: HOLD_TICKS >= 1; tick is a one-cycle pulse.
module rcc_hold_det #(
    parameter int HOLD_TICKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic btn_n,
    output logic fire
);
    localparam int CW = $clog2(HOLD_TICKS + 1);
    localparam logic [CW-1:0] FULL = CW'(HOLD_TICKS);
    localparam logic [CW-1:0] NEAR = CW'(HOLD_TICKS - 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;
    logic          active;

    // Two-stage synchroniser for the asynchronous button.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], btn_n};
    end

    assign active = ~sync_q[1];

    // Count ticks while held, saturating at the hold limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !active)              cnt_q <= '0;
        else if (tick && cnt_q != FULL)     cnt_q <= cnt_q + 1'b1;
    end

    // Pulse exactly when the count reaches the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) fire <= 1'b0;
        else        fire <= active && tick && (cnt_q == NEAR);
    end

    p_single_fire_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);
endmodule

// File: rtl/rcc_ctl_reg.sv
// Reset control register at one I/O port. Holds the full-reset bit (loaded
// on every write) and a sticky global bit (set by writes, cleared only by
// power-on reset). Flags software reset requests of the two trigger codes.
// Assumes: byte writes complete in one cycle.
module rcc_ctl_reg #(
    parameter int             AW        = 16,
    parameter logic [AW-1:0]  PORT_ADDR = AW'(16'h0CF9)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic          full_q,
    output logic          glb_q,
    output logic          sw_req,
    output logic          sw_full
);
    localparam logic [7:0] CODE_WARM = 8'h06;
    localparam logic [7:0] CODE_COLD = 8'h0E;
    localparam int         FULL_BIT  = 3;
    localparam int         GLB_BIT   = 7;

    logic hit;
    assign hit = wr_en && (addr == PORT_ADDR);

    // Load the full-reset bit from every register write.
    always_ff @(posedge clk) begin
        if (!rst_n)   full_q <= 1'b0;
        else if (hit) full_q <= wdata[FULL_BIT];
    end

    // Sticky global bit: set by a write, cleared only by power-on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                    glb_q <= 1'b0;
        else if (hit && wdata[GLB_BIT]) glb_q <= 1'b1;
    end

    assign sw_req  = hit && (wdata == CODE_WARM || wdata == CODE_COLD);
    assign sw_full = wdata[FULL_BIT];

    p_glb_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        glb_q |=> glb_q);
endmodule

// File: rtl/rcc_type_arbiter.sv
// Maps every event to a reset type, detects level edges, tracks the OS
// watchdog arm state and registers the highest requested type as a strobe.
// Assumes: event inputs are one-cycle pulses; levels are synchronous.
module rcc_type_arbiter
    import rcc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sw_req,
    input  logic       sw_full,
    input  logic       full_bit,
    input  logic       glb_bit,
    input  logic       btn_press,
    input  logic       pwr_override,
    input  logic       core_pwr_ok,
    input  logic       sys_in_s5,
    input  logic       therm_trip,
    input  logic       cpu_shutdown,
    input  logic       os_wdt_expire,
    input  logic       fw_wdt_expire,
    input  logic       host_rst_tmo,
    input  logic       s5_entry_tmo,
    output logic       rst_valid,
    output logic [2:0] rst_type
);
    logic             pok_q;
    logic             s5_q;
    logic             armed_q;
    logic             pwr_fail;
    logic             s5_enter;
    logic             wdt_second;
    logic [NUM_TYPES:1] req;
    logic [2:0]       sel;

    // Remember previous levels; seeded from inputs so reset makes no edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pok_q <= core_pwr_ok;
            s5_q  <= sys_in_s5;
        end else begin
            pok_q <= core_pwr_ok;
            s5_q  <= sys_in_s5;
        end
    end

    assign pwr_fail   = pok_q && !core_pwr_ok && !s5_q;
    assign s5_enter   = !s5_q && sys_in_s5;
    assign wdt_second = os_wdt_expire && armed_q;

    // Per-type request lines.
    always_comb begin
        req[1] = (sw_req && !glb_bit && !sw_full) || (btn_press && !full_bit)
               || wdt_second || (cpu_shutdown && !glb_bit && !full_bit);
        req[2] = (sw_req && !glb_bit && sw_full) || (btn_press && full_bit)
               || (cpu_shutdown && !glb_bit && full_bit);
        req[3] = s5_enter;
        req[4] = (sw_req && glb_bit) || pwr_fail || (cpu_shutdown && glb_bit)
               || host_rst_tmo;
        req[5] = therm_trip || pwr_override || s5_entry_tmo || fw_wdt_expire;
    end

    // Highest requested type wins.
    always_comb begin
        sel = RT_NONE;
        for (int i = 1; i <= NUM_TYPES; i++) begin
            if (req[i]) sel = 3'(i);
        end
    end

    // Arm on a first expiry; any issued reset disarms.
    always_ff @(posedge clk) begin
        if (!rst_n || (|req)) armed_q <= 1'b0;
        else if (os_wdt_expire) armed_q <= 1'b1;
    end

    // Register the decision strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_valid <= 1'b0;
            rst_type  <= RT_NONE;
        end else begin
            rst_valid <= |req;
            rst_type  <= sel;
        end
    end

    p_req_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |=> rst_valid);
    p_type_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_valid |-> (rst_type >= 3'd1 && rst_type <= 3'd5));
    p_wdt_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_valid |-> !armed_q);
endmodule

// File: rtl/rst_cause_classifier.sv
// Top of the reset cause classifier: control register, tick timebase,
// reset-button debounce, power-button override hold and type arbiter.
// Assumes: synchronous active-low power-on reset; pulse inputs last one cycle.
module rst_cause_classifier #(
    parameter int AW         = 16,
    parameter int PORT_ADDR  = 16'h0CF9,
    parameter int TICK_DIV   = 125000,
    parameter int DEB_TICKS  = 20,
    parameter int HOLD_TICKS = 4000
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          io_wr_en,
    input  logic [AW-1:0] io_addr,
    input  logic [7:0]    io_wr_data,
    input  logic          rst_btn_n,
    input  logic          pwr_btn_n,
    input  logic          core_pwr_ok,
    input  logic          sys_in_s5,
    input  logic          therm_trip,
    input  logic          cpu_shutdown,
    input  logic          os_wdt_expire,
    input  logic          fw_wdt_expire,
    input  logic          host_rst_tmo,
    input  logic          s5_entry_tmo,
    output logic          rst_valid,
    output logic [2:0]    rst_type
);
    logic tick;
    logic full_bit, glb_bit, sw_req, sw_full;
    logic btn_press, pwr_override;

    rcc_ctl_reg #(.AW(AW), .PORT_ADDR(AW'(PORT_ADDR))) u_ctl (
        .clk(clk), .rst_n(por_n), .wr_en(io_wr_en), .addr(io_addr),
        .wdata(io_wr_data), .full_q(full_bit), .glb_q(glb_bit),
        .sw_req(sw_req), .sw_full(sw_full)
    );

    rcc_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(por_n), .tick(tick)
    );

    rcc_hold_det #(.HOLD_TICKS(DEB_TICKS)) u_rst_btn (
        .clk(clk), .rst_n(por_n), .tick(tick), .btn_n(rst_btn_n), .fire(btn_press)
    );

    rcc_hold_det #(.HOLD_TICKS(HOLD_TICKS)) u_pwr_btn (
        .clk(clk), .rst_n(por_n), .tick(tick), .btn_n(pwr_btn_n), .fire(pwr_override)
    );

    rcc_type_arbiter u_arb (
        .clk(clk), .rst_n(por_n), .sw_req(sw_req), .sw_full(sw_full),
        .full_bit(full_bit), .glb_bit(glb_bit), .btn_press(btn_press),
        .pwr_override(pwr_override), .core_pwr_ok(core_pwr_ok),
        .sys_in_s5(sys_in_s5), .therm_trip(therm_trip),
        .cpu_shutdown(cpu_shutdown), .os_wdt_expire(os_wdt_expire),
        .fw_wdt_expire(fw_wdt_expire), .host_rst_tmo(host_rst_tmo),
        .s5_entry_tmo(s5_entry_tmo), .rst_valid(rst_valid), .rst_type(rst_type)
    );

    p_therm_type_r7: assert property (@(posedge clk) disable iff (!por_n)
        therm_trip |=> (rst_valid && rst_type == 3'd5));
    p_reset_quiet_r11: assert property (@(posedge clk)
        !por_n |=> !rst_valid);
endmodule

// File: tb/rst_cause_classifier_tb_top.sv
`timescale 1ns/1ps
module rst_cause_classifier_tb_top;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        io_wr_en = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wr_data = '0;
    logic        rst_btn_n = 1'b1, pwr_btn_n = 1'b1;
    logic        core_pwr_ok = 1'b1, sys_in_s5 = 1'b0;
    logic        therm_trip = 0, cpu_shutdown = 0, os_wdt_expire = 0;
    logic        fw_wdt_expire = 0, host_rst_tmo = 0, s5_entry_tmo = 0;
    logic        rst_valid;
    logic [2:0]  rst_type;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    rst_cause_classifier #(.TICK_DIV(2), .DEB_TICKS(3), .HOLD_TICKS(8)) dut_i (
        .clk(clk), .por_n(por_n), .io_wr_en(io_wr_en), .io_addr(io_addr),
        .io_wr_data(io_wr_data), .rst_btn_n(rst_btn_n), .pwr_btn_n(pwr_btn_n),
        .core_pwr_ok(core_pwr_ok), .sys_in_s5(sys_in_s5), .therm_trip(therm_trip),
        .cpu_shutdown(cpu_shutdown), .os_wdt_expire(os_wdt_expire),
        .fw_wdt_expire(fw_wdt_expire), .host_rst_tmo(host_rst_tmo),
        .s5_entry_tmo(s5_entry_tmo), .rst_valid(rst_valid), .rst_type(rst_type)
    );

    // Vector: wr, on_port, data[8], therm, shut, host, s5tmo, fw, os, ev, et[3], req[4]
    localparam int NV = 27;
    localparam logic [23:0] VEC [0:NV-1] = '{
        {1'b1,1'b1,8'h06,6'b000000,1'b1,3'd1,4'd2},  // R2 warm write
        {1'b1,1'b1,8'h0E,6'b000000,1'b1,3'd2,4'd2},  // R2 cold write, full=1
        {1'b1,1'b0,8'h0E,6'b000000,1'b0,3'd0,4'd2},  // R2 wrong address
        {1'b1,1'b1,8'h0A,6'b000000,1'b0,3'd0,4'd2},  // R2 other value, full=1
        {1'b0,1'b0,8'h00,6'b010000,1'b1,3'd2,4'd8},  // R8 shutdown, full=1
        {1'b1,1'b1,8'h06,6'b000000,1'b1,3'd1,4'd2},  // R2 full=0
        {1'b0,1'b0,8'h00,6'b010000,1'b1,3'd1,4'd8},  // R8 shutdown, full=0
        {1'b0,1'b0,8'h00,6'b000001,1'b0,3'd0,4'd5},  // R5 first expiry
        {1'b0,1'b0,8'h00,6'b000001,1'b1,3'd1,4'd5},  // R5 second expiry
        {1'b0,1'b0,8'h00,6'b000001,1'b0,3'd0,4'd5},  // R5 arm again
        {1'b0,1'b0,8'h00,6'b100000,1'b1,3'd5,4'd7},  // R7 thermal, disarms
        {1'b0,1'b0,8'h00,6'b000001,1'b0,3'd0,4'd5},  // R5 first after clear
        {1'b0,1'b0,8'h00,6'b001000,1'b1,3'd4,4'd9},  // R9 host timeout, disarms
        {1'b0,1'b0,8'h00,6'b000001,1'b0,3'd0,4'd5},  // R5 first after clear
        {1'b0,1'b0,8'h00,6'b010001,1'b1,3'd1,4'd10}, // R10 two type-1 sources
        {1'b0,1'b0,8'h00,6'b000100,1'b1,3'd5,4'd7},  // R7 S5 entry timeout
        {1'b0,1'b0,8'h00,6'b000010,1'b1,3'd5,4'd7},  // R7 firmware watchdog
        {1'b0,1'b0,8'h00,6'b011000,1'b1,3'd4,4'd10}, // R10 shutdown+host
        {1'b1,1'b1,8'h06,6'b100000,1'b1,3'd5,4'd10}, // R10 write+thermal
        {1'b0,1'b0,8'h00,6'b111000,1'b1,3'd5,4'd10}, // R10 triple
        {1'b0,1'b0,8'h00,6'b000000,1'b0,3'd0,4'd1},  // R1 idle
        {1'b1,1'b1,8'h80,6'b000000,1'b0,3'd0,4'd3},  // R3 set global bit
        {1'b1,1'b1,8'h06,6'b000000,1'b1,3'd4,4'd3},  // R3 warm escalated
        {1'b1,1'b1,8'h0E,6'b000000,1'b1,3'd4,4'd3},  // R3 cold escalated
        {1'b0,1'b0,8'h00,6'b010000,1'b1,3'd4,4'd8},  // R8 shutdown global
        {1'b1,1'b1,8'h00,6'b000000,1'b0,3'd0,4'd3},  // R3 write 0, bit sticks
        {1'b0,1'b0,8'h00,6'b010000,1'b1,3'd4,4'd3}   // R3 still global
    };

    task automatic check(input int rq, input logic ev, input logic [2:0] et);
        checks++;
        if (rst_valid !== ev || (ev && rst_type !== et)) begin
            errors++;
            $display("FAIL R%0d: valid=%b type=%0d expected valid=%b type=%0d",
                     rq, rst_valid, rst_type, ev, et);
        end
    endtask

    task automatic observe(input int n, output int cnt, output logic [2:0] last);
        cnt = 0;
        last = 3'd0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (rst_valid) begin
                cnt++;
                last = rst_type;
            end
        end
    endtask

    task automatic check_win(input int rq, input int cnt, input logic [2:0] last,
                             input int ecnt, input logic [2:0] et);
        checks++;
        if (cnt != ecnt || (ecnt > 0 && last !== et)) begin
            errors++;
            $display("FAIL R%0d: strobes=%0d type=%0d expected strobes=%0d type=%0d",
                     rq, cnt, last, ecnt, et);
        end
    endtask

    task automatic pulse_clear();
        io_wr_en = 0; therm_trip = 0; cpu_shutdown = 0; host_rst_tmo = 0;
        s5_entry_tmo = 0; fw_wdt_expire = 0; os_wdt_expire = 0;
    endtask

    initial begin
        int cnt;
        logic [2:0] last;
        repeat (3) @(negedge clk);
        check(11, 1'b0, 3'd0);                      // R11 quiet in reset
        por_n = 1;
        @(negedge clk);
        check(11, 1'b0, 3'd0);                      // R11 quiet after release

        for (int i = 0; i < NV; i++) begin
            io_wr_en      = VEC[i][23];
            io_addr       = VEC[i][22] ? 16'h0CF9 : 16'h0CF8;
            io_wr_data    = VEC[i][21:14];
            therm_trip    = VEC[i][13];
            cpu_shutdown  = VEC[i][12];
            host_rst_tmo  = VEC[i][11];
            s5_entry_tmo  = VEC[i][10];
            fw_wdt_expire = VEC[i][9];
            os_wdt_expire = VEC[i][8];
            @(negedge clk);
            pulse_clear();
            check(int'(VEC[i][3:0]), VEC[i][7], VEC[i][6:4]);
        end

        // R6 power-good and S5 levels
        core_pwr_ok = 0; @(negedge clk); check(6, 1'b1, 3'd4);
        core_pwr_ok = 1; @(negedge clk); check(6, 1'b0, 3'd0);
        sys_in_s5 = 1;   @(negedge clk); check(6, 1'b1, 3'd3);
        core_pwr_ok = 0; @(negedge clk); check(6, 1'b0, 3'd0);
        core_pwr_ok = 1; sys_in_s5 = 0; @(negedge clk); check(6, 1'b0, 3'd0);

        // R4 glitch shorter than debounce, then real presses
        rst_btn_n = 0; repeat (2) @(negedge clk); rst_btn_n = 1;
        observe(20, cnt, last); check_win(4, cnt, last, 0, 3'd0);
        rst_btn_n = 0;
        observe(40, cnt, last); check_win(4, cnt, last, 1, 3'd1); // global set, full=0
        rst_btn_n = 1; observe(6, cnt, last);
        io_addr = 16'h0CF9; io_wr_data = 8'h08; io_wr_en = 1;
        @(negedge clk); io_wr_en = 0; check(4, 1'b0, 3'd0);
        rst_btn_n = 0;
        observe(40, cnt, last); check_win(4, cnt, last, 1, 3'd2);
        rst_btn_n = 1; observe(6, cnt, last);

        // R7 power button override hold
        pwr_btn_n = 0;
        observe(10, cnt, last); check_win(7, cnt, last, 0, 3'd0);
        observe(40, cnt, last); check_win(7, cnt, last, 1, 3'd5);
        pwr_btn_n = 1; observe(6, cnt, last);

        // R11 power-on reset clears global and full bits and the arm
        por_n = 0; repeat (2) @(negedge clk); check(11, 1'b0, 3'd0);
        por_n = 1; @(negedge clk);
        cpu_shutdown = 1; @(negedge clk); pulse_clear(); check(11, 1'b1, 3'd1);
        os_wdt_expire = 1; @(negedge clk); pulse_clear(); check(11, 1'b0, 3'd0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule